// File: doc/BRIEF.md
# FIFO Watermark Service Request Generator

This block sits next to the transmit and receive FIFOs of an Ethernet MAC and decides when the DMA engine should be asked to move data. On the transmit side it compares the number of queued bytes against a threshold. The threshold is picked by a 5-bit code in steps of 64 bytes. When enough bytes are waiting, it holds a transmit service request.

On the receive side, a small state machine compares the occupied word count against a low and a high watermark. It presents either a low-priority or an urgent-priority service request, never both. The machine has three states:

- `RX_IDLE`: no request is presented.
- `RX_LOW`: the low watermark is reached, or a complete packet is buffered, and the high watermark is not reached.
- `RX_URGENT`: the high watermark is reached.

The state is re-evaluated on every clock. The transitions are:

- idle→low and urgent→low when the low condition holds and the high watermark is not reached.
- low→urgent and idle→urgent when the high watermark is reached.
- low→idle and urgent→idle when neither condition holds.

Crossing a watermark upward also emits a one-cycle pause-frame request for flow control. A pause caused by the low watermark carries a zero pause value. A pause caused by the high watermark carries a nonzero value.

Software should keep the low watermark above the 16-word DMA burst and below the receive FIFO size. It should also keep the high watermark above the low one and below the FIFO size. A flag reports when the high watermark is not strictly above the low one. The comparisons still use the programmed values in that case.

Top module: `fifo_wmark_req`

## Requirements
- R1: One cycle after `tx_fill_bytes >= (tx_thr_code + 1) * 64`, `tx_req` is 1; otherwise it is 0. Code 0 means 64 bytes and code 31 means 2048 bytes.
- R2: One cycle after `rx_fill_words >= rx_low_mark` while `rx_fill_words < rx_high_mark`, `rx_req_low` is 1 and `rx_req_urgent` is 0 (state `RX_LOW`).
- R3: One cycle after `rx_fill_words >= rx_high_mark`, `rx_req_urgent` is 1 and `rx_req_low` is 0 (state `RX_URGENT`). The two requests are never 1 together.
- R4: When `rx_pkt_done` is 1 and the high watermark is not reached, `rx_req_low` is 1 one cycle later, whatever the low watermark.
- R5: In the cycle after the occupancy first reaches the low watermark (it did not satisfy it the cycle before), `pause_req` pulses for one cycle with `pause_zero` = 1. This holds unless the high watermark is crossed in that same cycle.
- R6: In the cycle after the occupancy first reaches the high watermark, `pause_req` pulses for one cycle with `pause_zero` = 0. This applies also when both watermarks are crossed at once.
- R7: `pause_req` stays 0 while the watermark conditions hold unchanged, and when the occupancy falls.
- R8: One cycle after `rx_high_mark <= rx_low_mark`, `cfg_err` is 1; otherwise it is 0. The request outputs still follow R2 to R4 using the programmed values.
- R9: While `rst_n` is 0, every output is 0 at each clock and the receive machine is in `RX_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_fill_bytes | input | 12 | Bytes queued in the transmit FIFO |
| tx_thr_code | input | 5 | Transmit threshold code, threshold = (code+1)*64 bytes |
| rx_fill_words | input | 10 | 32-bit words occupied in the receive FIFO |
| rx_low_mark | input | 10 | Receive low watermark in words |
| rx_high_mark | input | 10 | Receive high watermark in words |
| rx_pkt_done | input | 1 | A complete packet is present in the receive FIFO |
| tx_req | output | 1 | Transmit service request |
| rx_req_low | output | 1 | Low-priority receive service request |
| rx_req_urgent | output | 1 | Urgent-priority receive service request |
| pause_req | output | 1 | One-cycle pause-frame request |
| pause_zero | output | 1 | Pause value is zero (valid with `pause_req`) |
| cfg_err | output | 1 | High watermark not above low watermark |

## Verification
Every output is one register away from its inputs. Each result is therefore due exactly one clock edge after the stimulus that causes it.

The bench drives inputs on the falling edge and samples 1 ns after the following rising edge. Pause pulses are predicted from the bench's own record of which watermark conditions held at the previous step. This lets the single-cycle pulse and its absence on the next step be checked at precise cycles.

The sweeps cover every threshold code at the threshold and at one byte either side. They also ramp the receive occupancy up and down through several watermark pairs, including an inverted pair and a jump over both marks at once.

// File: rtl/wm_pkg.sv
`timescale 1ns/1ps
package wm_pkg;
    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_LOW    = 2'd1,
        RX_URGENT = 2'd2
    } rx_state_e;
endpackage

// File: rtl/wm_tx_thresh.sv
`timescale 1ns/1ps
module wm_tx_thresh #(
    parameter int CODE_W    = 5,
    parameter int CNT_W     = 12,
    parameter int UNIT_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  fill_bytes,
    input  logic [CODE_W-1:0] thr_code,
    output logic              req
);
    localparam int THR_W = CODE_W + UNIT_LOG2 + 1;
    localparam int EXT_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic [THR_W-1:0] thr_bytes;
    logic             reached;

    always_comb begin
        thr_bytes = (THR_W'(thr_code) + THR_W'(1)) << UNIT_LOG2;
        reached   = EXT_W'(fill_bytes) >= EXT_W'(thr_bytes);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= reached;
    end

    // R1: a request only follows a cycle where the threshold was met
    p_tx_thresh_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(EXT_W'(fill_bytes) >=
                      EXT_W'((THR_W'(thr_code) + THR_W'(1)) << UNIT_LOG2)));
endmodule

// File: rtl/wm_rx_fsm.sv
`timescale 1ns/1ps
module wm_rx_fsm
    import wm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill_words,
    input  logic [CNT_W-1:0] low_mark,
    input  logic [CNT_W-1:0] high_mark,
    input  logic             pkt_done,
    output logic             lo_hit,
    output logic             hi_hit,
    output logic             req_low,
    output logic             req_urgent
);
    rx_state_e state_q, state_d;
    logic      low_cond;

    always_comb begin
        lo_hit   = fill_words >= low_mark;
        hi_hit   = fill_words >= high_mark;
        low_cond = lo_hit | pkt_done;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (hi_hit)        state_d = RX_URGENT;
                else if (low_cond) state_d = RX_LOW;
            end
            RX_LOW: begin
                if (hi_hit)         state_d = RX_URGENT;
                else if (!low_cond) state_d = RX_IDLE;
            end
            RX_URGENT: begin
                if (!hi_hit) state_d = low_cond ? RX_LOW : RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the registered state
    always_comb begin
        req_low    = 1'b0;
        req_urgent = 1'b0;
        unique case (state_q)
            RX_IDLE:   ;
            RX_LOW:    req_low    = 1'b1;
            RX_URGENT: req_urgent = 1'b1;
            default:   ;
        endcase
    end

    p_one_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_low && req_urgent));
    p_urgent_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_urgent |-> $past(fill_words >= high_mark));
    p_low_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_low |-> $past((fill_words >= low_mark || pkt_done) &&
                          !(fill_words >= high_mark)));
    p_pkt_forces_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !(fill_words >= high_mark)) |=> req_low);
endmodule

// File: rtl/wm_pause_gen.sv
`timescale 1ns/1ps
module wm_pause_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_hit,
    input  logic hi_hit,
    output logic pause_req,
    output logic pause_zero
);
    logic lo_q, hi_q;
    logic lo_rise, hi_rise;

    always_comb begin
        lo_rise = lo_hit & ~lo_q;
        hi_rise = hi_hit & ~hi_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q       <= 1'b0;
            hi_q       <= 1'b0;
            pause_req  <= 1'b0;
            pause_zero <= 1'b0;
        end else begin
            lo_q       <= lo_hit;
            hi_q       <= hi_hit;
            pause_req  <= lo_rise | hi_rise;
            pause_zero <= lo_rise & ~hi_rise;
        end
    end

    p_pause_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> ($past(lo_hit) || $past(hi_hit)));
    p_hi_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && !pause_zero) |=> !(pause_req && !pause_zero));
    p_zero_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pause_zero |-> pause_req);
endmodule

// File: rtl/fifo_wmark_req.sv
`timescale 1ns/1ps
module fifo_wmark_req #(
    parameter int TX_CNT_W = 12,
    parameter int TX_CODE_W = 5,
    parameter int TX_UNIT_LOG2 = 6,
    parameter int RX_CNT_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TX_CNT_W-1:0]  tx_fill_bytes,
    input  logic [TX_CODE_W-1:0] tx_thr_code,
    input  logic [RX_CNT_W-1:0]  rx_fill_words,
    input  logic [RX_CNT_W-1:0]  rx_low_mark,
    input  logic [RX_CNT_W-1:0]  rx_high_mark,
    input  logic                 rx_pkt_done,
    output logic                 tx_req,
    output logic                 rx_req_low,
    output logic                 rx_req_urgent,
    output logic                 pause_req,
    output logic                 pause_zero,
    output logic                 cfg_err
);
    logic lo_hit, hi_hit;

    wm_tx_thresh #(
        .CODE_W   (TX_CODE_W),
        .CNT_W    (TX_CNT_W),
        .UNIT_LOG2(TX_UNIT_LOG2)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_bytes(tx_fill_bytes),
        .thr_code  (tx_thr_code),
        .req       (tx_req)
    );

    wm_rx_fsm #(.CNT_W(RX_CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_words(rx_fill_words),
        .low_mark  (rx_low_mark),
        .high_mark (rx_high_mark),
        .pkt_done  (rx_pkt_done),
        .lo_hit    (lo_hit),
        .hi_hit    (hi_hit),
        .req_low   (rx_req_low),
        .req_urgent(rx_req_urgent)
    );

    wm_pause_gen u_pause (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_hit    (lo_hit),
        .hi_hit    (hi_hit),
        .pause_req (pause_req),
        .pause_zero(pause_zero)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= !(rx_high_mark > rx_low_mark);
    end

    p_cfg_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(rx_high_mark <= rx_low_mark));
    p_pause_hi_urgent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && !pause_zero) |-> rx_req_urgent);
    p_pause_lo_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && pause_zero) |-> (rx_req_low || rx_req_urgent));
    p_reset_quiet_r9: assert property (@(posedge clk)
        $past(!rst_n) |-> !(tx_req || rx_req_low || rx_req_urgent ||
                            pause_req || cfg_err));
endmodule

// File: tb/tb_fifo_wmark_req.sv
`timescale 1ns/1ps
module tb_fifo_wmark_req;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] tx_fill_bytes = '0;
    logic [4:0]  tx_thr_code = '0;
    logic [9:0]  rx_fill_words = '0;
    logic [9:0]  rx_low_mark = 10'd20;
    logic [9:0]  rx_high_mark = 10'd40;
    logic        rx_pkt_done = 1'b0;
    logic        tx_req, rx_req_low, rx_req_urgent, pause_req, pause_zero, cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit prev_lo = 0;
    bit prev_hi = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fifo_wmark_req dut (
        .clk(clk), .rst_n(rst_n),
        .tx_fill_bytes(tx_fill_bytes), .tx_thr_code(tx_thr_code),
        .rx_fill_words(rx_fill_words), .rx_low_mark(rx_low_mark),
        .rx_high_mark(rx_high_mark), .rx_pkt_done(rx_pkt_done),
        .tx_req(tx_req), .rx_req_low(rx_req_low), .rx_req_urgent(rx_req_urgent),
        .pause_req(pause_req), .pause_zero(pause_zero), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic tx_step(input int code, input int fill);
        @(negedge clk);
        tx_thr_code   = code[4:0];
        tx_fill_bytes = fill[11:0];
        @(posedge clk); #1;
        chk("R1", "tx_req", tx_req, fill >= (code + 1) * 64);
    endtask

    task automatic rx_step(input int fill, input bit pkt);
        bit lo, hi, hr, lr, ep;
        @(negedge clk);
        rx_fill_words = fill[9:0];
        rx_pkt_done   = pkt;
        @(posedge clk); #1;
        lo = fill >= rx_low_mark;
        hi = fill >= rx_high_mark;
        hr = hi && !prev_hi;
        lr = lo && !prev_lo;
        ep = hr || lr;
        chk("R3", "rx_req_urgent", rx_req_urgent, hi);
        chk(pkt ? "R4" : "R2", "rx_req_low", rx_req_low, !hi && (lo || pkt));
        chk(ep ? "R5/R6" : "R7", "pause_req", pause_req, ep);
        if (ep) chk(hr ? "R6" : "R5", "pause_zero", pause_zero, lr && !hr);
        chk("R8", "cfg_err", cfg_err, !(rx_high_mark > rx_low_mark));
        prev_lo = lo;
        prev_hi = hi;
    endtask

    task automatic set_marks(input int lo, input int hi);
        @(negedge clk);
        rx_low_mark  = lo[9:0];
        rx_high_mark = hi[9:0];
        rx_step(0, 0);
    endtask

    task automatic ramp(input int top);
        for (int f = 0; f <= top; f++) rx_step(f, (f % 7) == 3);
        for (int f = top; f >= 0; f--) rx_step(f, (f % 5) == 1);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R9: reset holds outputs low even with full FIFOs and bad marks
        tx_fill_bytes = 12'hFFF;
        rx_fill_words = 10'd500;
        rx_low_mark   = 10'd50;
        rx_high_mark  = 10'd10;
        rx_pkt_done   = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "tx_req", tx_req, 1'b0);
        chk("R9", "rx_req_low", rx_req_low, 1'b0);
        chk("R9", "rx_req_urgent", rx_req_urgent, 1'b0);
        chk("R9", "pause_req", pause_req, 1'b0);
        chk("R9", "cfg_err", cfg_err, 1'b0);
        @(negedge clk);
        tx_fill_bytes = '0;
        rx_fill_words = '0;
        rx_pkt_done   = 1'b0;
        rx_low_mark   = 10'd20;
        rx_high_mark  = 10'd40;
        rst_n         = 1'b1;
        @(posedge clk); #1;
        chk("R9", "pause_req after release", pause_req, 1'b0);

        // R1: every threshold code, just below, at and above the threshold
        for (int c = 0; c < 32; c++) begin
            tx_step(c, 0);
            tx_step(c, (c + 1) * 64 - 1);
            tx_step(c, (c + 1) * 64);
            tx_step(c, (c + 1) * 64 + 1);
            tx_step(c, 4095);
        end

        // R2..R8: receive ramps over several watermark pairs
        set_marks(20, 40);   ramp(45);
        set_marks(17, 300);  ramp(305);
        set_marks(18, 19);   ramp(25);
        set_marks(40, 20);   ramp(45);   // inverted marks, R8
        set_marks(30, 30);   ramp(35);   // equal marks, R8

        // R6: jump past both watermarks in one cycle
        set_marks(20, 40);
        rx_step(0, 0);
        rx_step(100, 0);
        rx_step(100, 0);     // R7 level held, no new pulse
        rx_step(30, 0);      // falling, R7
        rx_step(45, 0);      // re-cross high only, R6
        rx_step(0, 1);       // R4 packet present, empty FIFO
        rx_step(5, 1);

        finish_run();
    end
endmodule